// File: doc/BRIEF.md
# Trimmed RTC Seconds Predivider

This block turns a slow real-time-clock input (nominally 32.768 kHz) into a one-second tick and keeps a running count of seconds. A down-counting predivider produces one tick each time it reaches zero. On most seconds it then reloads a fixed nominal value. On the last second of every window of 2^WIN_W seconds (64 by default) it reloads a trim value that software has written. Raising the trim above nominal stretches that one second, and lowering it shortens that second. Drift in the oscillator can therefore be corrected in whole input cycles per window.

Software reaches three registers through a write-only bus: a control register, a trim register and a seconds preset. A write is accepted only when the write-ready qualifier is high. The bus and the counting logic share one clock. Alarms, subsecond readout and clock-domain crossing are not part of the block.

Top module: `rtc_trim_divider`

## Requirements
- R1: Reset clears the seconds count to 0, leaves counting stopped (no tick), and sets the trim register to the nominal value (0x7FFF by default).
- R2: With counting running, every second that is not a trim second lasts NOMINAL+1 input cycles, and one tick is issued per second.
- R3: Seconds are numbered from 0 after reset. Second s with s mod 2^WIN_W equal to 2^WIN_W-1 is the trim second, and it lasts TRIM+1 cycles, where TRIM is the trim register value held when the preceding second ended.
- R4: A trim value above nominal makes the trim second longer than nominal, so the clock runs slower. A trim value below nominal makes it shorter, so the clock runs faster.
- R5: A trim write made during a trim second does not alter that second; it takes effect at the next trim second.
- R6: A bus write with the write-ready qualifier low changes no register. This covers the run bit, the trim value and the seconds count.
- R7: Only data bits 15:0 of a trim write are stored. Bits 31:16 are discarded and have no effect on timing.
- R8: The seconds count increases by one on each tick. A preset write (address 2) loads the count, and a preset in the same cycle as a tick wins over the increment.
- R9: With the run bit (address 0, data bit 0) cleared, the predivider and the seconds count hold their values and no tick is issued.
- R10: The seconds count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 trim, 2 seconds preset |
| bus_wdata | input | 32 | Write data |
| bus_wr_rdy | input | 1 | Write-ready qualifier; writes are dropped while low |
| sec_tick | output | 1 | One-cycle pulse in the last input cycle of each second |
| sec_count | output | 32 | Elapsed seconds |

## Verification
The bench measures the length of every second and aims at the trim second. A design off by one in the window index stretches the wrong second. A design that reloads the live register instead of the value held at the previous second's end lets a write land mid-window. A trim write arrives inside a trim second, and writes with the ready qualifier low or with junk in the upper data bits follow. A design that ignores the qualifier or stores the upper bits would then produce wrong second lengths. A preset issued on the tick edge and a preset near the 32-bit limit catch an increment that beats the load or a count that saturates instead of wrapping.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_TRIM = 2'd1,
    SEL_SECS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
  import rtc_trim_pkg::*;
#(
  parameter int          DIV_W   = 16,
  parameter logic [15:0] NOMINAL = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr_rdy,
  output logic              run_o,
  output logic [DIV_W-1:0]  trim_o,
  output logic              secs_load_o,
  output logic [DATA_W-1:0] secs_val_o
);
  logic             wr_ok;
  logic             run_q, run_d;
  logic [DIV_W-1:0] trim_q, trim_d;

  assign wr_ok = bus_wr && bus_wr_rdy;

  always_comb begin
    run_d  = run_q;
    trim_d = trim_q;
    if (wr_ok && bus_addr == SEL_CTRL) run_d  = bus_wdata[0];
    if (wr_ok && bus_addr == SEL_TRIM) trim_d = bus_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      trim_q <= NOMINAL[DIV_W-1:0];
    end else begin
      run_q  <= run_d;
      trim_q <= trim_d;
    end
  end

  assign run_o       = run_q;
  assign trim_o      = trim_q;
  assign secs_load_o = wr_ok && (bus_addr == SEL_SECS);
  assign secs_val_o  = bus_wdata;

  // R6: no register moves without a qualified write
  a_r6_no_unready_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_wr_rdy) |=> $stable(run_q) && $stable(trim_q));
endmodule

// File: rtl/rtc_trim_prediv.sv
module rtc_trim_prediv #(
  parameter int          DIV_W   = 16,
  parameter logic [15:0] NOMINAL = 16'h7FFF,
  parameter int          WIN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] trim_i,
  output logic             tick_o
);
  localparam logic [WIN_W-1:0] WIN_LAST  = {WIN_W{1'b1}};
  localparam logic [WIN_W-1:0] TRIM_PREV = WIN_LAST - 1'b1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             tick;
  logic [DIV_W-1:0] reload;

  assign tick   = run_i && (cnt_q == '0);
  // trim is sampled at the end of the second before the window's last
  assign reload = (win_q == TRIM_PREV) ? trim_i : NOMINAL[DIV_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    win_d = win_q;
    if (tick) begin
      cnt_d = reload;
      win_d = win_q + 1'b1;
    end else if (run_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= NOMINAL[DIV_W-1:0];
      win_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

  assign tick_o = tick;

  // R2: running counter steps down by one between ticks
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3: a tick reloads either the nominal or the trim value
  a_r3_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == NOMINAL[DIV_W-1:0] || cnt_q == $past(trim_i));
  // R3: window index wraps after its last second
  a_r3_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o && win_q == WIN_LAST |=> win_q == '0);
  // R9: stopped predivider holds
  a_r9_hold_prediv: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q) && $stable(win_q));
endmodule

// File: rtl/rtc_trim_seconds.sv
module rtc_trim_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load_i)      count_d = load_val_i;
    else if (tick_i) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

  // R8 / R10: tick increments modulo 2^CNT_W
  a_r8_increment: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !load_i |=> count_q == $past(count_q) + 1'b1);
  // R8: preset wins
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_q == $past(load_val_i));
  // R9: no tick, no load, no change
  a_r9_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !load_i |=> $stable(count_q));
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int          DIV_W   = 16,
  parameter logic [15:0] NOMINAL = 16'h7FFF,
  parameter int          WIN_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr_rdy,
  output logic              sec_tick,
  output logic [DATA_W-1:0] sec_count
);
  logic              run;
  logic [DIV_W-1:0]  trim;
  logic              secs_load;
  logic [DATA_W-1:0] secs_val;
  logic              tick;

  rtc_trim_regs #(.DIV_W(DIV_W), .NOMINAL(NOMINAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr_rdy(bus_wr_rdy),
    .run_o(run), .trim_o(trim), .secs_load_o(secs_load), .secs_val_o(secs_val)
  );

  rtc_trim_prediv #(.DIV_W(DIV_W), .NOMINAL(NOMINAL), .WIN_W(WIN_W)) u_prediv (
    .clk(clk), .rst_n(rst_n), .run_i(run), .trim_i(trim), .tick_o(tick)
  );

  rtc_trim_seconds #(.CNT_W(DATA_W)) u_secs (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(secs_load),
    .load_val_i(secs_val), .count_o(sec_count)
  );

  assign sec_tick = tick;

  // R9: no tick while stopped
  a_r9_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sec_tick);
endmodule

// File: tb/rtc_trim_divider_tb.sv
module rtc_trim_divider_tb;
  localparam int NOM = 15;
  localparam int WW  = 2;
  localparam int WIN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr_rdy = 1'b0;
  logic        sec_tick;
  logic [31:0] sec_count;

  always #4 clk = ~clk;

  rtc_trim_divider #(.DIV_W(16), .NOMINAL(16'(NOM)), .WIN_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr_rdy(bus_wr_rdy),
    .sec_tick(sec_tick), .sec_count(sec_count)
  );

  int checks = 0, errors = 0, cyc = 0, ntick = 0;
  bit done = 1'b0;
  int t_arr [0:63];

  // behavioural reference
  int          m_cnt = NOM, m_win = 0, m_trim = NOM;
  bit          m_run = 1'b0;
  logic [31:0] m_sec = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit t, w;
    int old_trim;
    cyc++;
    if (!rst_n) begin
      m_cnt = NOM; m_win = 0; m_trim = NOM; m_run = 1'b0; m_sec = '0;
    end else begin
      t = m_run && m_cnt == 0;
      w = bus_wr && bus_wr_rdy;
      old_trim = m_trim;
      if (t) begin
        m_cnt = (m_win == WIN - 2) ? old_trim : NOM;
        m_win = (m_win + 1) % WIN;
      end else if (m_run) m_cnt = m_cnt - 1;
      if (w && bus_addr == 2'd2) m_sec = bus_wdata;
      else if (t) m_sec = m_sec + 32'd1;
      if (w && bus_addr == 2'd0) m_run = bus_wdata[0];
      if (w && bus_addr == 2'd1) m_trim = int'(bus_wdata[15:0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sec_tick == (m_run && m_cnt == 0), "R2/R3 tick vs model", sec_tick, m_run && m_cnt == 0);
      chk(sec_count == m_sec, "R8 count vs model", sec_count, m_sec);
      if (sec_tick && ntick < 64) begin
        t_arr[ntick] = cyc;
        ntick++;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit rdy);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wr_rdy = rdy;
    @(negedge clk);
    bus_wr = 1'b0; bus_wr_rdy = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    while (ntick < n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int hold, nt0, exp_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sec_count == 0, "R1 reset count", sec_count, 0);
    chk(sec_tick == 1'b0, "R1 no tick after reset", sec_tick, 0);

    // R6: run bit write with ready low is dropped
    wr(2'd0, 32'd1, 1'b0);
    repeat (40) @(negedge clk);
    chk(ntick == 0 && sec_count == 0, "R6 unready run write ignored", ntick, 0);

    wr(2'd0, 32'd1, 1'b1);
    wait_ticks(9);
    wr(2'd1, 32'hABCD_0013, 1'b1);     // R7: upper junk, trim 19
    wait_ticks(13);
    wr(2'd1, 32'd11, 1'b1);            // R4 faster
    wait_ticks(15);
    wr(2'd1, 32'd13, 1'b1);            // R5 written inside trim second 15
    wait_ticks(17);
    wr(2'd1, 32'd40, 1'b0);            // R6 ignored trim write
    wait_ticks(21);

    for (int s = 1; s <= 20; s++) begin
      exp_len = (s == 11) ? 20 : (s == 15) ? 12 : (s == 19) ? 14 : NOM + 1;
      if (s == 11)      chk(t_arr[s]-t_arr[s-1] == exp_len, "R4 R7 slow trim second", t_arr[s]-t_arr[s-1], exp_len);
      else if (s == 15) chk(t_arr[s]-t_arr[s-1] == exp_len, "R4 R5 fast trim second", t_arr[s]-t_arr[s-1], exp_len);
      else if (s == 19) chk(t_arr[s]-t_arr[s-1] == exp_len, "R5 R6 deferred trim second", t_arr[s]-t_arr[s-1], exp_len);
      else if (s == 3)  chk(t_arr[s]-t_arr[s-1] == exp_len, "R1 R3 default trim second", t_arr[s]-t_arr[s-1], exp_len);
      else              chk(t_arr[s]-t_arr[s-1] == exp_len, "R2 nominal second", t_arr[s]-t_arr[s-1], exp_len);
    end
    @(negedge clk);
    chk(sec_count == 21, "R8 seconds counted", sec_count, 21);

    // R9: stop holds everything
    wr(2'd0, 32'd0, 1'b1);
    hold = sec_count; nt0 = ntick;
    repeat (60) @(negedge clk);
    chk(sec_count == hold, "R9 count held", sec_count, hold);
    chk(ntick == nt0, "R9 no tick while stopped", ntick, nt0);
    wr(2'd0, 32'd1, 1'b1);

    // R10: wrap
    wr(2'd2, 32'hFFFF_FFFE, 1'b1);
    nt0 = ntick;
    wait_ticks(nt0 + 2);
    @(negedge clk);
    chk(sec_count == 0, "R10 count wraps", sec_count, 0);

    // R8: preset on the tick edge wins
    while (!sec_tick) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'd100; bus_wr_rdy = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wr_rdy = 1'b0;
    chk(sec_count == 100, "R8 preset beats tick", sec_count, 100);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule